// File: doc/BRIEF.md
# NCO Quadrature Up-Converter

This block shifts a complex baseband stream up to an intermediate frequency ahead of a pair of converter channels. Every clock it accepts one signed sample pair (I, Q), rotates it by the phase of a numerically controlled oscillator, and hands one 14-bit result to each of two output channels. The oscillator is a 32-bit phase accumulator stepped by a programmable tuning word. A separate 16-bit phase offset rotates the carrier as a whole. The top 10 bits of the offset phase address a sine/cosine generator built from a quarter-wave table with symmetry folding.

Configuration arrives one byte at a time over a small write port. The tuning word and the phase offset are each assembled in a staging register, and the full word takes effect only when its most significant byte is written, so the oscillator never runs on a half-updated value. A control byte turns the mixing on or off and selects how the input samples are read. When mixing is off, the converted inputs pass straight through with the same latency as the mixed path.

Top module: `nco_quad_mod`

## Requirements
- R1: While `rst_n` is low at a clock edge, the phase accumulator, the tuning word, the phase offset and the control byte clear to zero, and both outputs read 0 one edge later.
- R2: At each clock edge the phase accumulator adds the current tuning word, modulo 2^32. The table phase is bits [15:6] of (accumulator[31:16] + phase offset), taken modulo 2^16.
- R3: The tuning word is written LSB first. Write addresses 0, 1 and 2 load bytes 0..2 into a staging register. A write to address 3 loads the whole word (address-3 byte in bits [31:24]) in one edge. Writes to addresses 0..2 alone leave the active word unchanged.
- R4: Phase offset bytes go to address 4 (bits [7:0], staged) and address 5 (bits [15:8]). The offset changes only on the address-5 write.
- R5: Control byte at address 6: bit 0 enables mixing and bit 1 selects offset-binary input. Both are 0 after reset (bypass, two's complement).
- R6: With mixing on, out_a = I·C − Q·S and out_b = I·S + Q·C. S and C are the sine and cosine of 2π·phase/1024, scaled to ±32767. Each output appears two clock edges after its inputs and phase are sampled.
- R7: Each product sum is divided by 2^15 with round-half-up: (sum + 2^14) >> 15, arithmetic.
- R8: Results above 8191 give 8191, and results below −8192 give −8192.
- R9: With mixing off, out_a equals the converted I and out_b equals the converted Q, with the same two-edge latency.
- R10: In offset-binary mode the input MSB is inverted to form the two's-complement value (0x0000 → −8192, 0x3FFF → 8191).
- R11: The generator returns exact values at quadrant points: S = 0 at table phases 0 and 512, C = +32767 at phase 0, and C = −32767 at phase 512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 3 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration byte |
| in_i | input | 14 | In-phase input sample |
| in_q | input | 14 | Quadrature input sample |
| out_a | output | 14 | Channel A result (two's complement) |
| out_b | output | 14 | Channel B result (two's complement) |

## Verification
The bench targets the points where a near-miss design still looks plausible:
- **Quadrant points.** A wrong fold direction or an off-by-one mirror index would leave sine slightly off zero or cosine short of full scale.
- **Staged writes.** A tuning word or phase offset applied from a low byte would start the carrier rotating before the top byte lands.
- **Extreme inputs at 45 degrees.** Full-scale equal I and Q at 45 degrees push channel B past the 14-bit range; a missing clamp would wrap the result to the opposite sign.
- **Single-LSB inputs.** These expose truncation in place of rounding.
- **Mid-run reset.** A reset during rotation shows whether the accumulator restarts at zero phase.
- **Offset-binary inputs.** These show whether the MSB inversion is missing in either the bypass path or the mixing path.

// File: rtl/nqm_pkg.sv
// Package: shared types and elaboration-time helpers for the NCO quadrature
// up-converter. Assumes a quarter-wave table sized by the caller.
package nqm_pkg;

    // Control byte fields: bit 1 input format, bit 0 mixing enable.
    typedef struct packed {
        logic fmt_ob;
        logic mix_en;
    } nqm_ctrl_t;

    // pi/2 in Q30 fixed point.
    localparam longint HALF_PI_Q30 = 64'sd1686629713;

    // Quarter-wave sine entry k of qn steps, scaled to amp, computed by a
    // fixed-point Taylor series at elaboration time.
    function automatic int qw_sin(input int k, input int qn, input int amp);
        longint x;
        longint term;
        longint sum;
        x    = (longint'(k) * HALF_PI_Q30) / longint'(qn);
        term = x;
        sum  = x;
        for (int n = 1; n <= 9; n++) begin
            term = (term * x) >>> 30;
            term = (term * x) >>> 30;
            term = -term / longint'((2 * n) * (2 * n + 1));
            sum  = sum + term;
        end
        return int'((sum * longint'(amp) + (longint'(1) <<< 29)) >>> 30);
    endfunction

endpackage

// File: rtl/nqm_cfg_regs.sv
// Module: byte-wide configuration registers. The tuning word and the phase
// offset are staged byte by byte and committed when their top byte is
// written. Assumes ACC_W and OFF_W are multiples of 8, each at least 16.
module nqm_cfg_regs
    import nqm_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [ACC_W-1:0]  ftw,
    output logic [OFF_W-1:0]  poff,
    output nqm_ctrl_t         ctrl
);
    localparam int FTW_BYTES = ACC_W / 8;
    localparam int OFF_BYTES = OFF_W / 8;
    localparam int FTW_TOP   = FTW_BYTES - 1;
    localparam int OFF_BASE  = FTW_BYTES;
    localparam int OFF_TOP   = OFF_BASE + OFF_BYTES - 1;
    localparam int CTRL_ADDR = OFF_BASE + OFF_BYTES;

    logic [ACC_W-9:0] ftw_stg;
    logic [OFF_W-9:0] off_stg;

    // Stage low bytes; commit full words on their top-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_stg <= '0;
            off_stg <= '0;
            ftw     <= '0;
            poff    <= '0;
            ctrl    <= '0;
        end else if (we) begin
            for (int b = 0; b < FTW_TOP; b++) begin
                if (addr == ADDR_W'(b)) ftw_stg[b*8 +: 8] <= wdata;
            end
            if (addr == ADDR_W'(FTW_TOP)) ftw <= {wdata, ftw_stg};
            for (int b = 0; b < OFF_BYTES - 1; b++) begin
                if (addr == ADDR_W'(OFF_BASE + b)) off_stg[b*8 +: 8] <= wdata;
            end
            if (addr == ADDR_W'(OFF_TOP)) poff <= {wdata, off_stg};
            if (addr == ADDR_W'(CTRL_ADDR)) ctrl <= nqm_ctrl_t'(wdata[1:0]);
        end
    end

    AST_FTW_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we && addr == ADDR_W'(FTW_TOP)) |-> $stable(ftw)); // R3
    AST_POFF_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we && addr == ADDR_W'(OFF_TOP)) |-> $stable(poff)); // R4

endmodule

// File: rtl/nqm_phase_acc.sv
// Module: phase accumulator. It steps by the tuning word every clock and
// forms the table address from the upper accumulator bits plus the phase
// offset. Assumes PHW <= OFF_W <= ACC_W.
module nqm_phase_acc #(
    parameter int ACC_W = 32,
    parameter int OFF_W = 16,
    parameter int PHW   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] ftw,
    input  logic [OFF_W-1:0] poff,
    output logic [PHW-1:0]   lut_addr
);
    localparam int DROP = OFF_W - PHW;

    logic [ACC_W-1:0] acc_q;

    // Advance the phase by one tuning step per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + ftw;
    end

    // Offset the coarse phase and keep the table-address bits.
    always_comb begin
        lut_addr = PHW'((acc_q[ACC_W-1 -: OFF_W] + poff) >> DROP);
    end

    AST_ACC_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0)); // R1
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ftw) == '0) |-> $stable(acc_q)); // R2

endmodule

// File: rtl/nqm_sincos.sv
// Module: registered sine/cosine generator from a quarter-wave table with
// symmetry folding. The table is computed at elaboration. Assumes PHW >= 3.
module nqm_sincos
    import nqm_pkg::*;
#(
    parameter int PHW = 10,
    parameter int TW  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PHW-1:0]       addr,
    output logic signed [TW-1:0] sin_q,
    output logic signed [TW-1:0] cos_q
);
    localparam int QB  = PHW - 2;
    localparam int QN  = 1 << QB;
    localparam int AMP = (1 << (TW - 1)) - 1;

    logic signed [TW-1:0] lut [0:QN];

    // Elaboration-time quarter-wave table, QN+1 entries.
    for (genvar k = 0; k <= QN; k++) begin : g_lut
        assign lut[k] = TW'(qw_sin(k, QN, AMP));
    end

    logic [1:0]           quad;
    logic [QB:0]          idx_fwd;
    logic [QB:0]          idx_rev;
    logic signed [TW-1:0] v_fwd;
    logic signed [TW-1:0] v_rev;
    logic signed [TW-1:0] sin_d;
    logic signed [TW-1:0] cos_d;

    // Fold the phase into the first quadrant and pick signs.
    always_comb begin
        quad    = addr[PHW-1 -: 2];
        idx_fwd = {1'b0, addr[QB-1:0]};
        idx_rev = (QB+1)'(QN) - idx_fwd;
        v_fwd   = lut[idx_fwd];
        v_rev   = lut[idx_rev];
        case (quad)
            2'd0:    begin sin_d =  v_fwd; cos_d =  v_rev; end
            2'd1:    begin sin_d =  v_rev; cos_d = -v_fwd; end
            2'd2:    begin sin_d = -v_fwd; cos_d = -v_rev; end
            default: begin sin_d = -v_rev; cos_d =  v_fwd; end
        endcase
    end

    // Register the carrier samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_q <= '0;
            cos_q <= '0;
        end else begin
            sin_q <= sin_d;
            cos_q <= cos_d;
        end
    end

    AST_SIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[PHW-2:0] == '0) |=> (sin_q == '0)); // R11
    AST_COS_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |=> (cos_q == TW'(AMP))); // R11
    AST_COS_TROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == PHW'(1 << (PHW - 1))) |=> (cos_q == -TW'(AMP))); // R11

endmodule

// File: rtl/nqm_mixer.sv
// Module: complex mixer with format conversion, rounding, saturation and
// bypass. Inputs are registered in the same edge as the carrier, and the
// result one edge later. Assumes carrier full scale is 2^(TW-1)-1.
module nqm_mixer
    import nqm_pkg::*;
#(
    parameter int DW = 14,
    parameter int TW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  nqm_ctrl_t            ctrl,
    input  logic [DW-1:0]        in_i,
    input  logic [DW-1:0]        in_q,
    input  logic signed [TW-1:0] sin_v,
    input  logic signed [TW-1:0] cos_v,
    output logic [DW-1:0]        out_a,
    output logic [DW-1:0]        out_b
);
    localparam int SW = DW + TW + 1;
    localparam logic signed [SW-1:0] RND  = SW'(1) <<< (TW - 2);
    localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] MINV = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [DW-1:0] i_s;
    logic signed [DW-1:0] q_s;
    logic                 en_s;
    logic signed [SW-1:0] sum_a;
    logic signed [SW-1:0] sum_b;
    logic signed [SW-1:0] sh_a;
    logic signed [SW-1:0] sh_b;

    // Clamp a scaled result into the output range.
    function automatic logic [DW-1:0] clamp(input logic signed [SW-1:0] v);
        if (v > MAXV)      return MAXV[DW-1:0];
        else if (v < MINV) return MINV[DW-1:0];
        else               return v[DW-1:0];
    endfunction

    // Capture inputs in two's complement together with the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_s  <= '0;
            q_s  <= '0;
            en_s <= 1'b0;
        end else begin
            i_s  <= ctrl.fmt_ob ? {~in_i[DW-1], in_i[DW-2:0]} : in_i;
            q_s  <= ctrl.fmt_ob ? {~in_q[DW-1], in_q[DW-2:0]} : in_q;
            en_s <= ctrl.mix_en;
        end
    end

    // Complex rotation and round-half-up scaling.
    always_comb begin
        sum_a = SW'(i_s) * SW'(cos_v) - SW'(q_s) * SW'(sin_v);
        sum_b = SW'(i_s) * SW'(sin_v) + SW'(q_s) * SW'(cos_v);
        sh_a  = (sum_a + RND) >>> (TW - 1);
        sh_b  = (sum_b + RND) >>> (TW - 1);
    end

    // Register either the clamped mix or the bypassed samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a <= '0;
            out_b <= '0;
        end else if (en_s) begin
            out_a <= clamp(sh_a);
            out_b <= clamp(sh_b);
        end else begin
            out_a <= i_s;
            out_b <= q_s;
        end
    end

    AST_ZERO_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && i_s == '0 && q_s == '0) |=> (out_a == '0 && out_b == '0)); // R6

endmodule

// File: rtl/nco_quad_mod.sv
// Module: top of the NCO quadrature up-converter. It joins the configuration
// registers, phase accumulator, sine/cosine generator and mixer. Latency from
// inputs to outputs is two clock edges. Assumes synchronous active-low reset.
module nco_quad_mod
    import nqm_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int OFF_W  = 16,
    parameter int PHW    = 10,
    parameter int DW     = 14,
    parameter int TW     = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [DW-1:0]     in_i,
    input  logic [DW-1:0]     in_q,
    output logic [DW-1:0]     out_a,
    output logic [DW-1:0]     out_b
);
    logic [ACC_W-1:0]     ftw;
    logic [OFF_W-1:0]     poff;
    nqm_ctrl_t            ctrl;
    logic [PHW-1:0]       lut_addr;
    logic signed [TW-1:0] sin_v;
    logic signed [TW-1:0] cos_v;

    nqm_cfg_regs #(.ACC_W(ACC_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .ftw(ftw), .poff(poff), .ctrl(ctrl)
    );

    nqm_phase_acc #(.ACC_W(ACC_W), .OFF_W(OFF_W), .PHW(PHW)) u_acc (
        .clk(clk), .rst_n(rst_n), .ftw(ftw), .poff(poff), .lut_addr(lut_addr)
    );

    nqm_sincos #(.PHW(PHW), .TW(TW)) u_sc (
        .clk(clk), .rst_n(rst_n), .addr(lut_addr), .sin_q(sin_v), .cos_q(cos_v)
    );

    nqm_mixer #(.DW(DW), .TW(TW)) u_mix (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .in_i(in_i), .in_q(in_q),
        .sin_v(sin_v), .cos_v(cos_v), .out_a(out_a), .out_b(out_b)
    );

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(ctrl.mix_en, 2))
        |-> (out_a == $past({in_i[DW-1] ^ ctrl.fmt_ob, in_i[DW-2:0]}, 2)
          && out_b == $past({in_q[DW-1] ^ ctrl.fmt_ob, in_q[DW-2:0]}, 2))); // R9

endmodule

// File: tb/nco_quad_mod_bench.sv
module nco_quad_mod_bench;

    typedef struct packed {
        logic [31:0] ftw;
        logic [15:0] poff;
        logic [1:0]  ctrl;
        logic [13:0] i;
        logic [13:0] q;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [0:NV-1] = '{
        '{32'h0000_0000, 16'h0000, 2'b00, 14'(1234),  14'(-2000)},
        '{32'h0000_0000, 16'h0000, 2'b10, 14'h3000,   14'h0100},
        '{32'h0000_0000, 16'h0000, 2'b01, 14'(3000),  14'(-700)},
        '{32'h4000_0000, 16'h0000, 2'b01, 14'(5000),  14'(-3000)},
        '{32'h0123_4567, 16'h2000, 2'b01, 14'(4000),  14'(1500)},
        '{32'h1000_0000, 16'h1234, 2'b11, 14'h0000,   14'h3FFF},
        '{32'hFFFF_0000, 16'h8000, 2'b01, 14'(-8192), 14'(-8192)}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [13:0] in_i = '0;
    logic [13:0] in_q = '0;
    logic [13:0] out_a;
    logic [13:0] out_b;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    chk_on = 1'b1;
    string tag_ovr = "R1";

    always #2 clk = ~clk;

    nco_quad_mod u_nco_quad_mod (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_i(in_i), .in_q(in_q),
        .out_a(out_a), .out_b(out_b)
    );

    // Behavioural reference state, built from the requirements.
    logic [31:0] m_acc, m_ftw;
    logic [23:0] m_fstg;
    logic [15:0] m_poff;
    logic [7:0]  m_pstg;
    logic [1:0]  m_ctrl;
    logic [13:0] p1_i, p1_q, p2_i, p2_q;
    logic [1:0]  p1_c, p2_c;
    logic [9:0]  p1_ph, p2_ph;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc <= '0; m_ftw <= '0; m_fstg <= '0; m_poff <= '0; m_pstg <= '0;
            m_ctrl <= '0;
            p1_i <= '0; p1_q <= '0; p1_c <= '0; p1_ph <= '0;
            p2_i <= '0; p2_q <= '0; p2_c <= '0; p2_ph <= '0;
        end else begin
            m_acc <= m_acc + m_ftw;
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_fstg[7:0]   <= cfg_wdata;
                    3'd1: m_fstg[15:8]  <= cfg_wdata;
                    3'd2: m_fstg[23:16] <= cfg_wdata;
                    3'd3: m_ftw <= {cfg_wdata, m_fstg};
                    3'd4: m_pstg <= cfg_wdata;
                    3'd5: m_poff <= {cfg_wdata, m_pstg};
                    3'd6: m_ctrl <= cfg_wdata[1:0];
                    default: ;
                endcase
            end
            p1_i <= in_i; p1_q <= in_q; p1_c <= m_ctrl;
            p1_ph <= 10'((m_acc[31:16] + m_poff) >> 6);
            p2_i <= p1_i; p2_q <= p1_q; p2_c <= p1_c; p2_ph <= p1_ph;
        end
    end

    function automatic int sat14(input int v);
        if (v > 8191) return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    function automatic void ref_out(input logic [13:0] i, input logic [13:0] q,
                                    input logic [1:0] c, input logic [9:0] ph,
                                    output int ea, output int eb, output int tol);
        logic [13:0] ci, cq;
        int si, sq, cv, sv;
        real th;
        ci = c[1] ? {~i[13], i[12:0]} : i;
        cq = c[1] ? {~q[13], q[12:0]} : q;
        si = int'($signed(ci));
        sq = int'($signed(cq));
        if (!c[0]) begin
            ea = si; eb = sq; tol = 0;
        end else begin
            th = 2.0 * 3.14159265358979 * $itor(ph) / 1024.0;
            cv = int'(32767.0 * $cos(th));
            sv = int'(32767.0 * $sin(th));
            ea = sat14((si * cv - sq * sv + 16384) >>> 15);
            eb = sat14((si * sv + sq * cv + 16384) >>> 15);
            tol = (ph[7:0] == 8'd0) ? 0 : 1;
        end
    endfunction

    task automatic chk(input int act, input int exp, input int tol,
                       input string tag, input string what);
        int d;
        n_cmp++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Continuous comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            int ea, eb, tol;
            string tg;
            ref_out(p2_i, p2_q, p2_c, p2_ph, ea, eb, tol);
            if (tag_ovr != "") tg = tag_ovr;
            else if (p2_c[1]) tg = "R10";
            else if (!p2_c[0]) tg = "R9";
            else if (tol == 0) tg = "R11";
            else tg = "R6";
            chk(int'($signed(out_a)), ea, tol, tg, "out_a");
            chk(int'($signed(out_b)), eb, tol, tg, "out_b");
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        cycles(n);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        // R1: reset state
        cycles(3);
        chk(int'($signed(out_a)), 0, 0, "R1", "reset out_a");
        chk(int'($signed(out_b)), 0, 0, "R1", "reset out_b");
        rst_n = 1'b1;
        tag_ovr = "";

        // Vector table walk (R2, R5, R6, R9, R10, R11)
        for (int v = 0; v < NV; v++) begin
            vec_t cv;
            cv = VECS[v];
            wr(3'd0, cv.ftw[7:0]);
            wr(3'd1, cv.ftw[15:8]);
            wr(3'd2, cv.ftw[23:16]);
            wr(3'd3, cv.ftw[31:24]);
            wr(3'd4, cv.poff[7:0]);
            wr(3'd5, cv.poff[15:8]);
            wr(3'd6, {6'd0, cv.ctrl});
            in_i = cv.i; in_q = cv.q;
            cycles(10);
        end

        // R1: mid-run reset restarts at zero phase
        tag_ovr = "R1";
        do_reset(3);
        wr(3'd6, 8'h01);
        in_i = 14'(4000); in_q = 14'd0;
        cycles(3);
        chk(int'($signed(out_a)), 4000, 0, "R1", "phase zero after reset a");
        chk(int'($signed(out_b)), 0, 0, "R1", "phase zero after reset b");

        // R7: single-LSB rounding at phase 0
        tag_ovr = "R7";
        in_i = 14'd1; in_q = 14'd0;
        cycles(3);
        chk(int'($signed(out_a)), 1, 0, "R7", "+1 rounds to 1");
        in_i = 14'(-1);
        cycles(3);
        chk(int'($signed(out_a)), -1, 0, "R7", "-1 rounds to -1");
        in_i = 14'd0; in_q = 14'd1;
        cycles(3);
        chk(int'($signed(out_b)), 1, 0, "R7", "Q +1 on channel B");

        // R3: staged tuning bytes do not rotate the carrier
        tag_ovr = "R3";
        in_i = 14'(6000); in_q = 14'd0;
        wr(3'd0, 8'h40); wr(3'd1, 8'h40); wr(3'd2, 8'h40);
        cycles(4);
        chk(int'($signed(out_a)), 5999, 1, "R3", "no rotation before top byte");
        chk(int'($signed(out_b)), 0, 0, "R3", "no rotation before top byte b");
        wr(3'd3, 8'h40);
        cycles(6);

        // R4: low offset byte alone has no effect, top byte commits
        tag_ovr = "R4";
        do_reset(2);
        wr(3'd6, 8'h01);
        wr(3'd4, 8'h00);
        in_i = 14'(3000); in_q = 14'd0;
        cycles(3);
        chk(int'($signed(out_b)), 0, 0, "R4", "offset staged only");
        wr(3'd5, 8'h40);
        cycles(3);
        chk(int'($signed(out_a)), 0, 0, "R4", "offset 90 deg a");
        chk(int'($signed(out_b)), 3000, 0, "R4", "offset 90 deg b");

        // R8: saturation at 45 degrees with full-scale inputs
        tag_ovr = "R8";
        wr(3'd5, 8'h20);
        in_i = 14'(-8192); in_q = 14'(-8192);
        cycles(3);
        chk(int'($signed(out_a)), 0, 0, "R8", "equal inputs cancel on A");
        chk(int'($signed(out_b)), -8192, 0, "R8", "negative clamp");
        in_i = 14'(8191); in_q = 14'(8191);
        cycles(3);
        chk(int'($signed(out_b)), 8191, 0, "R8", "positive clamp");

        // R5: control byte defaults to bypass after reset
        tag_ovr = "R5";
        do_reset(2);
        in_i = 14'(-77); in_q = 14'(55);
        cycles(3);
        chk(int'($signed(out_a)), -77, 0, "R5", "default bypass a");
        chk(int'($signed(out_b)), 55, 0, "R5", "default bypass b");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule